// File: doc/BRIEF.md
# Interrupt destination mask generator

This block turns an interrupt command into the set of agents that should receive it. The command arrives as two 32-bit words: a high word that holds only the destination byte and a low word that holds the vector, delivery mode, addressing mode, level, trigger mode and a 2-bit shorthand. Writing the high word just stores it. Writing the low word starts a send, and the block resolves the targets against per-agent tables of physical ID, 8-bit logical ID and 4-bit logical model.

A target can be named by physical ID, with 0xFF meaning every agent. It can also be named by logical matching, and each agent chooses flat or cluster matching through its model nibble. A shorthand can override the destination field. For lowest-priority delivery the mask is cut down to the lowest-indexed agent. An INIT command with level 0 and trigger 1 delivers nothing. It instead raises a resync pulse for the agents it addresses. The result is registered one clock after the send strobe.

The result interface is a plain single-cycle valid pulse with no ready input. There is no back-pressure, so the consumer must take every pulse in the cycle it appears. Sends may be issued on back-to-back cycles.

Top module: `irq_dest_gen`

## Requirements
- R1: A low-word write (`cmd_lo_wr`) produces exactly one registered result one clock later. Output fields are taken from the low word:
  - `out_vector` = bits [7:0]
  - `out_dmode` = bits [10:8]
  - `out_trig` = bit 15

  In cycles without a send, `out_valid`, `out_mask`, `resync_pulse` and `resync_mask` are all 0.
- R2: A high-word write only stores the destination (bits [31:24]) and produces no output. A send uses the stored destination. When both words are written in the same cycle, the newly written destination is used.
- R3: Shorthand (low bits [19:18]) value 1 targets only the sender, given by `sender_idx`.
- R4: Shorthand 2 targets every agent. Shorthand 3 targets every agent except the sender. Shorthand 0 uses the destination field.
- R5: Physical mode (low bit 11 = 0) behaves as follows:
  - A destination of 0xFF selects every agent.
  - Otherwise it selects the lowest-indexed agent whose physical ID equals the destination.
  - If no agent matches, the mask is empty and `out_valid` is still 1.
- R6: In logical mode (bit 11 = 1), an agent with model 0xF matches when destination AND its logical ID is nonzero.
- R7: In logical mode, an agent with model 0x0 matches when the upper nibbles of destination and logical ID are equal and the AND of the lower nibbles is nonzero. Any other model never matches.
- R8: Delivery mode code 1 (lowest priority) keeps only the lowest-indexed set bit of the target mask.
- R9: Delivery mode code 5 (INIT) with level (bit 14) = 0 and trigger (bit 15) = 1 gives `out_valid` = 0 and an empty `out_mask`. It also raises `resync_pulse` for one cycle, with `resync_mask` equal to the addressed agents.
- R10: Reserved delivery mode code 3 gives `out_valid` = 0 and an empty mask. The other codes (0 fixed, 2, 4, 5 with other level/trigger, 6, 7) are delivered to the full target mask.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_hi_wr | input | 1 | Store the high command word |
| cmd_hi_data | input | 32 | High command word; destination in [31:24] |
| cmd_lo_wr | input | 1 | Low command word write; starts a send |
| cmd_lo_data | input | 32 | Low command word |
| sender_idx | input | IDX_W | Index of the sending agent |
| agent_phys_id | input | N_AGENTS*8 | Physical ID of each agent, agent i in bits [8i+7:8i] |
| agent_log_id | input | N_AGENTS*8 | Logical ID of each agent |
| agent_model | input | N_AGENTS*4 | Logical model nibble of each agent |
| out_valid | output | 1 | One-cycle pulse: a command is delivered |
| out_mask | output | N_AGENTS | Target agents, bit i = agent i |
| out_vector | output | 8 | Vector of the delivered command |
| out_dmode | output | 3 | Delivery mode of the delivered command |
| out_trig | output | 1 | Trigger mode of the delivered command |
| resync_pulse | output | 1 | One-cycle pulse for an INIT-deassert command |
| resync_mask | output | N_AGENTS | Agents addressed by the INIT-deassert command |

## Verification
Every result of this block appears exactly one clock after the rising edge that samples `cmd_lo_wr`. This holds for the delivered mask and fields, for the resync pulse, and for the absence of output on a reserved code. A high-word write must show nothing at that same point. The bench drives inputs on the falling edge and holds the strobe for one cycle. It reads the outputs on the next falling edge, half a period after the registering edge. It also checks one cycle later that idle cycles show no pulse.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'd0,
    DM_LOWEST = 3'd1,
    DM_SMI    = 3'd2,
    DM_RSVD   = 3'd3,
    DM_NMI    = 3'd4,
    DM_INIT   = 3'd5,
    DM_START  = 3'd6,
    DM_EXT    = 3'd7
  } dmode_e;

  typedef enum logic [1:0] {
    SH_DEST   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  typedef struct packed {
    logic [7:0] vector;
    dmode_e     dmode;
    logic       logical;
    logic       level;
    logic       trig;
    shorthand_e sh;
  } cmd_t;

  localparam logic [3:0] MODEL_FLAT    = 4'hF;
  localparam logic [3:0] MODEL_CLUSTER = 4'h0;
  localparam logic [7:0] DEST_BCAST    = 8'hFF;

endpackage

// File: rtl/irq_agent_match.sv
module irq_agent_match
  import irq_dest_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic [ID_W-1:0] dest,
  input  logic [ID_W-1:0] phys_id,
  input  logic [ID_W-1:0] log_id,
  input  logic [3:0]      model,
  output logic            phys_hit,
  output logic            log_hit
);
  localparam int HALF = ID_W / 2;

  logic flat_hit;
  logic clus_hit;

  always_comb begin
    phys_hit = (phys_id == dest);
    flat_hit = |(dest & log_id);
    clus_hit = (dest[ID_W-1:HALF] == log_id[ID_W-1:HALF]) &&
               (|(dest[HALF-1:0] & log_id[HALF-1:0]));
    unique case (model)
      MODEL_FLAT:    log_hit = flat_hit;
      MODEL_CLUSTER: log_hit = clus_hit;
      default:       log_hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int N = 16
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  logic [N-1:0] below;

  // below[i] is set when some lower-indexed request exists
  always_comb begin
    below[0] = 1'b0;
    for (int i = 1; i < N; i++) below[i] = below[i-1] | req[i-1];
    grant = req & ~below;
  end
endmodule

// File: rtl/irq_target_resolve.sv
module irq_target_resolve
  import irq_dest_pkg::*;
#(
  parameter int N     = 16,
  parameter int ID_W  = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [ID_W-1:0]   dest,
  input  logic              logical,
  input  shorthand_e        sh,
  input  logic [IDX_W-1:0]  sender_idx,
  input  logic [N*ID_W-1:0] phys_ids,
  input  logic [N*ID_W-1:0] log_ids,
  input  logic [N*4-1:0]    models,
  output logic [N-1:0]      target
);
  logic [N-1:0] phys_hit;
  logic [N-1:0] log_hit;
  logic [N-1:0] phys_one;
  logic [N-1:0] addressed;
  logic [N-1:0] self_mask;

  for (genvar g = 0; g < N; g++) begin : g_agent
    irq_agent_match #(.ID_W(ID_W)) u_match (
      .dest    (dest),
      .phys_id (phys_ids[g*ID_W +: ID_W]),
      .log_id  (log_ids[g*ID_W +: ID_W]),
      .model   (models[g*4 +: 4]),
      .phys_hit(phys_hit[g]),
      .log_hit (log_hit[g])
    );
  end

  irq_lowest_pick #(.N(N)) u_phys_pick (
    .req  (phys_hit),
    .grant(phys_one)
  );

  always_comb begin
    self_mask = N'(1) << sender_idx;
    if (logical)                         addressed = log_hit;
    else if (dest == ID_W'(DEST_BCAST))  addressed = '1;
    else                                 addressed = phys_one;
    unique case (sh)
      SH_DEST:   target = addressed;
      SH_SELF:   target = self_mask;
      SH_ALL:    target = '1;
      SH_OTHERS: target = ~self_mask;
      default:   target = '0;
    endcase
  end
endmodule

// File: rtl/irq_dest_gen.sv
module irq_dest_gen
  import irq_dest_pkg::*;
#(
  parameter int N_AGENTS = 16,
  parameter int IDX_W    = $clog2(N_AGENTS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_hi_wr,
  input  logic [31:0]           cmd_hi_data,
  input  logic                  cmd_lo_wr,
  input  logic [31:0]           cmd_lo_data,
  input  logic [IDX_W-1:0]      sender_idx,
  input  logic [N_AGENTS*8-1:0] agent_phys_id,
  input  logic [N_AGENTS*8-1:0] agent_log_id,
  input  logic [N_AGENTS*4-1:0] agent_model,
  output logic                  out_valid,
  output logic [N_AGENTS-1:0]   out_mask,
  output logic [7:0]            out_vector,
  output logic [2:0]            out_dmode,
  output logic                  out_trig,
  output logic                  resync_pulse,
  output logic [N_AGENTS-1:0]   resync_mask
);
  localparam int ID_W = 8;

  logic [ID_W-1:0]     dest_q;
  logic [ID_W-1:0]     dest_eff;
  cmd_t                cmd;
  logic [N_AGENTS-1:0] target;
  logic [N_AGENTS-1:0] lowest;
  logic [N_AGENTS-1:0] deliver_mask;
  logic                init_deassert;
  logic                deliver;
  logic                unused_bits;

  assign unused_bits = ^{cmd_hi_data[23:0], cmd_lo_data[31:20],
                         cmd_lo_data[17:16], cmd_lo_data[13:12]};

  // destination store; a same-cycle high write bypasses the register
  always_ff @(posedge clk) begin
    if (!rst_n)         dest_q <= '0;
    else if (cmd_hi_wr) dest_q <= cmd_hi_data[31:24];
  end
  assign dest_eff = cmd_hi_wr ? cmd_hi_data[31:24] : dest_q;

  always_comb begin
    cmd.vector  = cmd_lo_data[7:0];
    cmd.dmode   = dmode_e'(cmd_lo_data[10:8]);
    cmd.logical = cmd_lo_data[11];
    cmd.level   = cmd_lo_data[14];
    cmd.trig    = cmd_lo_data[15];
    cmd.sh      = shorthand_e'(cmd_lo_data[19:18]);
  end

  irq_target_resolve #(.N(N_AGENTS), .ID_W(ID_W), .IDX_W(IDX_W)) u_resolve (
    .dest      (dest_eff),
    .logical   (cmd.logical),
    .sh        (cmd.sh),
    .sender_idx(sender_idx),
    .phys_ids  (agent_phys_id),
    .log_ids   (agent_log_id),
    .models    (agent_model),
    .target    (target)
  );

  irq_lowest_pick #(.N(N_AGENTS)) u_lowest (
    .req  (target),
    .grant(lowest)
  );

  always_comb begin
    init_deassert = (cmd.dmode == DM_INIT) && !cmd.level && cmd.trig;
    deliver       = (cmd.dmode != DM_RSVD) && !init_deassert;
    deliver_mask  = (cmd.dmode == DM_LOWEST) ? lowest : target;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_mask     <= '0;
      out_vector   <= '0;
      out_dmode    <= '0;
      out_trig     <= 1'b0;
      resync_pulse <= 1'b0;
      resync_mask  <= '0;
    end else begin
      out_valid    <= cmd_lo_wr && deliver;
      out_mask     <= (cmd_lo_wr && deliver) ? deliver_mask : '0;
      out_vector   <= (cmd_lo_wr && deliver) ? cmd.vector : '0;
      out_dmode    <= (cmd_lo_wr && deliver) ? cmd.dmode : DM_FIXED;
      out_trig     <= cmd_lo_wr && deliver && cmd.trig;
      resync_pulse <= cmd_lo_wr && init_deassert;
      resync_mask  <= (cmd_lo_wr && init_deassert) ? target : '0;
    end
  end
endmodule

// File: rtl/irq_dest_gen_chk.sv
module irq_dest_gen_chk #(
  parameter int N_AGENTS = 16,
  parameter int IDX_W    = $clog2(N_AGENTS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_lo_wr,
  input logic [31:0]         cmd_lo_data,
  input logic [IDX_W-1:0]    sender_idx,
  input logic                out_valid,
  input logic [N_AGENTS-1:0] out_mask,
  input logic                resync_pulse,
  input logic [N_AGENTS-1:0] resync_mask
);
  // R1: no result without a send one cycle earlier
  a_r1_no_idle_output: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cmd_lo_wr) |-> (!out_valid && !resync_pulse && out_mask == '0 && resync_mask == '0));

  // R3: self shorthand targets only the sender
  a_r3_self_only: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(cmd_lo_data[19:18]) == 2'd1) |->
      out_mask == (N_AGENTS'(1) << $past(sender_idx)));

  // R4: all-but-sender shorthand never includes the sender
  a_r4_others_exclude: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(cmd_lo_data[19:18]) == 2'd3) |->
      !out_mask[$past(sender_idx)]);

  // R8: lowest-priority result has at most one target
  a_r8_lowest_single: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(cmd_lo_data[10:8]) == 3'd1) |-> $onehot0(out_mask));

  // R9: INIT-deassert never delivers, and the two pulses never coincide
  a_r9_resync_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && resync_pulse));

  // R10: reserved delivery code yields nothing
  a_r10_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_lo_wr) && $past(cmd_lo_data[10:8]) == 3'd3) |->
      (!out_valid && out_mask == '0 && !resync_pulse));
endmodule

bind irq_dest_gen irq_dest_gen_chk #(.N_AGENTS(N_AGENTS), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_lo_wr   (cmd_lo_wr),
  .cmd_lo_data (cmd_lo_data),
  .sender_idx  (sender_idx),
  .out_valid   (out_valid),
  .out_mask    (out_mask),
  .resync_pulse(resync_pulse),
  .resync_mask (resync_mask)
);

// File: tb/irq_dest_gen_bench.sv
module irq_dest_gen_bench;
  localparam int N      = 16;
  localparam int IDX_W  = 4;
  localparam int CLK_P  = 10;
  localparam int WD_CYC = 5000;

  typedef struct packed {
    logic [31:0] lo;
    logic [7:0]  dest;
    logic [3:0]  snd;
    logic        val;
    logic [15:0] mask;
    logic [15:0] rsync;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{32'h0000_0041, 8'h25, 4'd0, 1'b1, 16'h0020, 16'h0000},
    '{32'h0000_0030, 8'hFF, 4'd0, 1'b1, 16'hFFFF, 16'h0000},
    '{32'h0000_0031, 8'h23, 4'd0, 1'b1, 16'h0008, 16'h0000},
    '{32'h0000_0032, 8'h99, 4'd0, 1'b1, 16'h0000, 16'h0000},
    '{32'h0000_0850, 8'h05, 4'd0, 1'b1, 16'h0005, 16'h0000},
    '{32'h0000_0851, 8'h13, 4'd0, 1'b1, 16'h0313, 16'h0000},
    '{32'h0000_0852, 8'h26, 4'd0, 1'b1, 16'h3026, 16'h0000},
    '{32'h0000_0953, 8'h26, 4'd0, 1'b1, 16'h0002, 16'h0000},
    '{32'h0004_0060, 8'h99, 4'd6, 1'b1, 16'h0040, 16'h0000},
    '{32'h0008_0061, 8'h99, 4'd6, 1'b1, 16'hFFFF, 16'h0000},
    '{32'h000C_0062, 8'h99, 4'd6, 1'b1, 16'hFFBF, 16'h0000},
    '{32'h000C_0163, 8'h99, 4'd0, 1'b1, 16'h0002, 16'h0000},
    '{32'h0000_0370, 8'hFF, 4'd0, 1'b0, 16'h0000, 16'h0000},
    '{32'h0000_8571, 8'hFF, 4'd0, 1'b0, 16'h0000, 16'hFFFF},
    '{32'h0000_C572, 8'hFF, 4'd0, 1'b1, 16'hFFFF, 16'h0000},
    '{32'h0000_8473, 8'h2A, 4'd0, 1'b1, 16'h0400, 16'h0000}
  };
  localparam string TAGS [NV] = '{
    "R5 phys", "R5 bcast", "R5 dup id", "R5 no match", "R6 flat",
    "R7 cluster", "R7 cluster2", "R8 lowest", "R3 self", "R4 all",
    "R4 others", "R8 others lowest", "R10 reserved", "R9 init deassert",
    "R10 init assert", "R1 nmi trig"
  };

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                cmd_hi_wr = 1'b0;
  logic [31:0]         cmd_hi_data = '0;
  logic                cmd_lo_wr = 1'b0;
  logic [31:0]         cmd_lo_data = '0;
  logic [IDX_W-1:0]    sender_idx = '0;
  logic [N*8-1:0]      agent_phys_id;
  logic [N*8-1:0]      agent_log_id;
  logic [N*4-1:0]      agent_model;
  logic                out_valid;
  logic [N-1:0]        out_mask;
  logic [7:0]          out_vector;
  logic [2:0]          out_dmode;
  logic                out_trig;
  logic                resync_pulse;
  logic [N-1:0]        resync_mask;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_dest_gen #(.N_AGENTS(N)) u_irq_dest_gen (
    .clk(clk), .rst_n(rst_n),
    .cmd_hi_wr(cmd_hi_wr), .cmd_hi_data(cmd_hi_data),
    .cmd_lo_wr(cmd_lo_wr), .cmd_lo_data(cmd_lo_data),
    .sender_idx(sender_idx),
    .agent_phys_id(agent_phys_id), .agent_log_id(agent_log_id),
    .agent_model(agent_model),
    .out_valid(out_valid), .out_mask(out_mask), .out_vector(out_vector),
    .out_dmode(out_dmode), .out_trig(out_trig),
    .resync_pulse(resync_pulse), .resync_mask(resync_mask)
  );

  // Agent tables: phys 0x20+i (agent 12 duplicates 0x23); 0-7 flat with
  // logical 1<<i; 8-13 cluster; 14-15 model 5 with logical 0xFF.
  initial begin
    for (int i = 0; i < N; i++) begin
      agent_phys_id[i*8 +: 8] = (i == 12) ? 8'h23 : 8'(8'h20 + i);
      if (i < 8) begin
        agent_model[i*4 +: 4]  = 4'hF;
        agent_log_id[i*8 +: 8] = 8'(1 << i);
      end else if (i < 14) begin
        agent_model[i*4 +: 4]  = 4'h0;
        agent_log_id[i*8 +: 8] = (i < 11) ? 8'(8'h10 | (1 << (i - 8)))
                                          : 8'(8'h20 | (1 << (i - 11)));
      end else begin
        agent_model[i*4 +: 4]  = 4'h5;
        agent_log_id[i*8 +: 8] = 8'hFF;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic write_hi(input logic [7:0] d);
    @(negedge clk);
    cmd_hi_wr = 1'b1; cmd_hi_data = {d, 24'h0};
    @(negedge clk);
    cmd_hi_wr = 1'b0;
  endtask

  task automatic send_lo(input logic [31:0] lo, input logic [3:0] snd);
    @(negedge clk);
    cmd_lo_wr = 1'b1; cmd_lo_data = lo; sender_idx = snd;
    @(negedge clk);
    cmd_lo_wr = 1'b0;
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset", {out_valid, out_mask, out_vector, out_dmode, out_trig, resync_pulse, resync_mask}, '0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      write_hi(TBL[v].dest);
      send_lo(TBL[v].lo, TBL[v].snd);
      chk(TAGS[v], {out_valid, out_mask, resync_pulse, resync_mask},
          {TBL[v].val, TBL[v].mask, |TBL[v].rsync, TBL[v].rsync});
      if (TBL[v].val)
        chk({TAGS[v], " R1 fields"}, {out_vector, out_dmode, out_trig},
            {TBL[v].lo[7:0], TBL[v].lo[10:8], TBL[v].lo[15]});
      @(negedge clk);
      chk({TAGS[v], " R1 idle"}, {out_valid, resync_pulse}, 2'b00);
    end

    // R2: high write alone gives no output
    write_hi(8'h25);
    chk("R2 hi only", {out_valid, resync_pulse, out_mask}, '0);
    // R2: the stored destination is used by a later send
    send_lo(32'h0000_0044, 4'd0);
    chk("R2 stored dest", {out_valid, out_mask}, {1'b1, 16'h0020});
    // R2: same-cycle high and low writes use the new destination
    @(negedge clk);
    cmd_hi_wr = 1'b1; cmd_hi_data = 32'h2B00_0000;
    cmd_lo_wr = 1'b1; cmd_lo_data = 32'h0000_0045;
    @(negedge clk);
    cmd_hi_wr = 1'b0; cmd_lo_wr = 1'b0;
    chk("R2 bypass", {out_valid, out_mask}, {1'b1, 16'h0800});
    // R1: back-to-back sends each produce their own result
    @(negedge clk);
    cmd_lo_wr = 1'b1; cmd_lo_data = 32'h0004_0046; sender_idx = 4'd3;
    @(negedge clk);
    chk("R3 b2b first", {out_valid, out_mask}, {1'b1, 16'h0008});
    cmd_lo_data = 32'h0004_0047; sender_idx = 4'd15;
    @(negedge clk);
    cmd_lo_wr = 1'b0;
    chk("R3 b2b second", {out_valid, out_mask, out_vector}, {1'b1, 16'h8000, 8'h47});
    // R11: reset mid-run clears outputs
    @(negedge clk);
    cmd_lo_wr = 1'b1; cmd_lo_data = 32'h0008_0048;
    @(negedge clk);
    cmd_lo_wr = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    chk("R11 reset clears", {out_valid, out_mask, out_vector}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule